// File: doc/BRIEF.md
# Small 64-bit integer execution core

This block is a single-cycle processor for a narrow slice of the 64-bit RISC-V base integer instruction set. Every clock cycle it presents its program counter on the instruction port and takes back one 32-bit instruction word in the same cycle. It decodes the R, I and S field layouts and reads two source registers from a 32 x 64-bit register file. It then computes with an adder/subtractor/left-shifter. Loads and stores go out on a data port that answers in the same cycle.

The supported operations are register add and subtract, add-immediate, shift-left-immediate with a 6-bit amount, and doubleword and word loads and stores. Any other encoding is reported on a flag. A flagged instruction changes nothing, and the program counter steps on as usual. Control flow, multiply, traps and pipelining are not part of the block.

Top module: `rv64_mini_core`

## Requirements
- R1: While reset is low the program counter is 0, and every general register reads as zero after reset until it is written.
- R2: The program counter advances by exactly 4 on every clock edge out of reset, whatever the instruction.
- R3: Register index 0 always reads as zero. Results aimed at index 0 are dropped.
- R4: add is decoded from opcode 0110011, funct3 000 and funct7 0000000, with rd in bits 11:7, rs1 in 19:15 and rs2 in 24:20. For example, 0x015A04B3 writes x20+x21 into x9, and 0x00650333 writes x10+x6 into x6.
- R5: sub (opcode 0110011, funct3 000, funct7 0100000) writes rs1 minus rs2, wrapping modulo 2^64.
- R6: addi (opcode 0010011, funct3 000) adds the 12-bit two's-complement immediate in bits 31:20, sign-extended to 64 bits. A negative immediate therefore subtracts.
- R7: slli (opcode 0010011, funct3 001, bits 31:26 = 000000) shifts rs1 left by the 6-bit amount in bits 25:20, so amounts from 32 to 63 work. A nonzero value in bits 31:26 with funct3 001 is unsupported.
- R8: Loads (opcode 0000011) request address rs1 + sign-extended bits 31:20 with write enable low. For funct3 011 (ld) the size signal is high and the full 64-bit read data is written. For funct3 010 (lw) the size signal is low and the low 32 read bits are written, sign-extended. Read data is the little-endian doubleword starting at the address.
- R9: Stores (opcode 0100011) take their offset from bits 31:25 (offset bits 11:5) and bits 11:7 (offset bits 4:0). They request rs1 + offset with write enable high and write no register. For funct3 011 (sd) the size signal is high and the write data is rs2. For funct3 010 (sw) the size signal is low and the write data is the low 32 bits of rs2 with the upper 32 bits zero.
- R10: Any other encoding raises the illegal flag for that cycle. It makes no memory request and writes no register. The flag is low for every supported instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | PC_W (64) | Program counter, the fetch address |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_req | output | 1 | Data access this cycle |
| dmem_we | output | 1 | 1 = store, 0 = load |
| dmem_dword | output | 1 | 1 = 64-bit access, 0 = 32-bit access |
| dmem_addr | output | XLEN (64) | Byte address, base plus offset |
| dmem_wdata | output | XLEN (64) | Store data, right-justified |
| dmem_rdata | input | XLEN (64) | Little-endian doubleword read at dmem_addr, same cycle |
| illegal | output | 1 | Current instruction is not supported |

## Verification
The bench goes after the split store offset, using offsets with both halves nonzero, with only the upper half set, and negative. A decoder that read the I-format position for stores would emit the wrong address, and one that kept rd for stores would overwrite the register named by the low offset bits. Shift amounts of 40 and 63 expose a 5-bit shift field, which would produce a shift by 8 or 31. Word loads of a word with the top bit set and one without separate sign extension from zero extension. Register 0 is targeted by both addi and add to catch a file that lets writes through. Illegal encodings borrow valid opcodes with bad funct fields, which a loose decoder would execute.

// File: rtl/rvm_pkg.sv
`timescale 1ns/1ps
package rvm_pkg;
   localparam logic [6:0] OPC_REG   = 7'b0110011;
   localparam logic [6:0] OPC_IMM   = 7'b0010011;
   localparam logic [6:0] OPC_LOAD  = 7'b0000011;
   localparam logic [6:0] OPC_STORE = 7'b0100011;

   localparam logic [2:0] F3_ADD  = 3'b000;
   localparam logic [2:0] F3_SLL  = 3'b001;
   localparam logic [2:0] F3_WORD = 3'b010;
   localparam logic [2:0] F3_DBL  = 3'b011;

   localparam logic [6:0] F7_BASE = 7'b0000000;
   localparam logic [6:0] F7_ALT  = 7'b0100000;

   typedef enum logic [3:0] {
      K_ILL, K_ADD, K_SUB, K_ADDI, K_SLLI, K_LD, K_LW, K_SD, K_SW
   } kind_e;

   typedef enum logic [1:0] {
      ALU_ADD, ALU_SUB, ALU_SLL
   } alu_e;
endpackage

// File: rtl/rvm_decode.sv
`timescale 1ns/1ps
module rvm_decode
   import rvm_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [31:0]     insn,
   output kind_e           kind,
   output logic [4:0]      rd,
   output logic [4:0]      rs1,
   output logic [4:0]      rs2,
   output logic [XLEN-1:0] imm
);
   localparam int IMM_W = 12;

   logic [6:0]       opc;
   logic [2:0]       f3;
   logic [6:0]       f7;
   logic [IMM_W-1:0] imm12;

   assign opc = insn[6:0];
   assign f3  = insn[14:12];
   assign f7  = insn[31:25];
   assign rd  = insn[11:7];
   assign rs1 = insn[19:15];
   assign rs2 = insn[24:20];

   // stores carry the offset in two pieces around the rs1/rs2 fields
   assign imm12 = (opc == OPC_STORE) ? {insn[31:25], insn[11:7]} : insn[31:20];
   assign imm   = {{(XLEN-IMM_W){imm12[IMM_W-1]}}, imm12};

   always_comb begin
      kind = K_ILL;
      unique case (opc)
         OPC_REG: begin
            if (f3 == F3_ADD && f7 == F7_BASE)     kind = K_ADD;
            else if (f3 == F3_ADD && f7 == F7_ALT) kind = K_SUB;
         end
         OPC_IMM: begin
            if (f3 == F3_ADD)                             kind = K_ADDI;
            else if (f3 == F3_SLL && insn[31:26] == 6'd0) kind = K_SLLI;
         end
         OPC_LOAD: begin
            if (f3 == F3_WORD)     kind = K_LW;
            else if (f3 == F3_DBL) kind = K_LD;
         end
         OPC_STORE: begin
            if (f3 == F3_WORD)     kind = K_SW;
            else if (f3 == F3_DBL) kind = K_SD;
         end
         default: kind = K_ILL;
      endcase
   end
endmodule

// File: rtl/rvm_alu.sv
`timescale 1ns/1ps
module rvm_alu
   import rvm_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  alu_e            op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] y
);
   localparam int SHW = $clog2(XLEN);

   always_comb begin
      unique case (op)
         ALU_SUB: y = a - b;
         ALU_SLL: y = a << b[SHW-1:0];
         default: y = a + b;
      endcase
   end
endmodule

// File: rtl/rvm_regfile.sv
`timescale 1ns/1ps
module rvm_regfile #(
   parameter int XLEN       = 64,
   parameter int NREG       = 32,
   parameter bit RESET_REGS = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [$clog2(NREG)-1:0] waddr,
   input  logic [XLEN-1:0]         wdata,
   input  logic [$clog2(NREG)-1:0] raddr_a,
   output logic [XLEN-1:0]         rdata_a,
   input  logic [$clog2(NREG)-1:0] raddr_b,
   output logic [XLEN-1:0]         rdata_b
);
   localparam int AW = $clog2(NREG);

   logic [XLEN-1:0] regs [0:NREG-1];
   logic            wr_hit;

   assign wr_hit = we && (waddr != AW'(0));

   generate
      if (RESET_REGS) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < NREG; i++) regs[i] <= '0;
            end else if (wr_hit) begin
               regs[waddr] <= wdata;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (wr_hit) regs[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata_a = (raddr_a == AW'(0)) ? '0 : regs[raddr_a];
   assign rdata_b = (raddr_b == AW'(0)) ? '0 : regs[raddr_b];

   // R3: a write aimed at index 0 is never visible on a read port next cycle
   a_r3_zero_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == AW'(0) && wdata != '0) |=> (raddr_a != AW'(0) || rdata_a == '0));
endmodule

// File: rtl/rv64_mini_core.sv
`timescale 1ns/1ps
module rv64_mini_core
   import rvm_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int NREG       = 32,
   parameter int PC_W       = 64,
   parameter bit RESET_REGS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [PC_W-1:0] imem_addr,
   input  logic [31:0]     imem_rdata,
   output logic            dmem_req,
   output logic            dmem_we,
   output logic            dmem_dword,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   input  logic [XLEN-1:0] dmem_rdata,
   output logic            illegal
);
   localparam int AW   = $clog2(NREG);
   localparam int HALF = 32;
   localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

   generate
      if (XLEN != 64) begin : g_bad_xlen
         $error("rv64_mini_core: XLEN must be 64");
      end
      if (NREG != 32) begin : g_bad_nreg
         $error("rv64_mini_core: NREG must be 32 to match 5-bit fields");
      end
      if (PC_W < 3) begin : g_bad_pcw
         $error("rv64_mini_core: PC_W too small");
      end
   endgenerate

   logic [PC_W-1:0] pc;
   kind_e           kind;
   logic [4:0]      rd, rs1, rs2;
   logic [XLEN-1:0] imm, rs1_val, rs2_val, alu_b, alu_y, wb_data;
   alu_e            alu_op;
   logic            rf_we, is_load, is_store;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= '0;
      else        pc <= pc + PC_STEP;
   end
   assign imem_addr = pc;

   rvm_decode #(.XLEN(XLEN)) u_dec (
      .insn(imem_rdata), .kind(kind), .rd(rd), .rs1(rs1), .rs2(rs2), .imm(imm)
   );

   rvm_regfile #(.XLEN(XLEN), .NREG(NREG), .RESET_REGS(RESET_REGS)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .we(rf_we), .waddr(AW'(rd)), .wdata(wb_data),
      .raddr_a(AW'(rs1)), .rdata_a(rs1_val),
      .raddr_b(AW'(rs2)), .rdata_b(rs2_val)
   );

   always_comb begin
      unique case (kind)
         K_SUB:   alu_op = ALU_SUB;
         K_SLLI:  alu_op = ALU_SLL;
         default: alu_op = ALU_ADD;
      endcase
   end

   assign alu_b = (kind == K_ADD || kind == K_SUB) ? rs2_val : imm;

   rvm_alu #(.XLEN(XLEN)) u_alu (
      .op(alu_op), .a(rs1_val), .b(alu_b), .y(alu_y)
   );

   assign is_load  = (kind == K_LD) || (kind == K_LW);
   assign is_store = (kind == K_SD) || (kind == K_SW);
   assign rf_we    = (kind == K_ADD) || (kind == K_SUB) || (kind == K_ADDI)
                  || (kind == K_SLLI) || is_load;

   always_comb begin
      unique case (kind)
         K_LD:    wb_data = dmem_rdata;
         K_LW:    wb_data = {{(XLEN-HALF){dmem_rdata[HALF-1]}}, dmem_rdata[HALF-1:0]};
         default: wb_data = alu_y;
      endcase
   end

   assign dmem_req   = is_load || is_store;
   assign dmem_we    = is_store;
   assign dmem_dword = (kind == K_LD) || (kind == K_SD);
   assign dmem_addr  = alu_y;
   assign dmem_wdata = (kind == K_SW) ? {{(XLEN-HALF){1'b0}}, rs2_val[HALF-1:0]} : rs2_val;
   assign illegal    = (kind == K_ILL);

   // R2: fetch address steps by four on every edge out of reset
   a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> imem_addr == $past(imem_addr) + PC_STEP);

   // R3: source field 0 always yields zero from the register file
   a_r3_src_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (imem_rdata[19:15] == 5'd0) |-> (rs1_val == '0));

   // R8: a load reads memory and never drives a write
   a_r8_load_reads: assert property (@(posedge clk) disable iff (!rst_n)
      is_load |-> (dmem_req && !dmem_we && rf_we));

   // R9: a store leaves the register file untouched
   a_r9_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_we |-> (!rf_we && dmem_req));

   // R10: an unsupported word has no side effect
   a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!dmem_req && !rf_we));
endmodule

// File: tb/sim_rv64_mini_core.sv
`timescale 1ns/1ps
module sim_rv64_mini_core;
   localparam logic [6:0] O_REG = 7'b0110011, O_IMM = 7'b0010011;
   localparam logic [6:0] O_LD  = 7'b0000011, O_ST  = 7'b0100011;
   localparam logic [31:0] NOP  = 32'h00000013;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] imem_addr;
   logic [31:0] imem_rdata;
   logic        dmem_req, dmem_we, dmem_dword, illegal;
   logic [63:0] dmem_addr, dmem_wdata, dmem_rdata;

   logic [31:0] prog [0:31];
   logic [7:0]  dm   [0:255];
   int          nchk = 0, nerr = 0, cur = 0;

   always #4 clk = ~clk;

   rv64_mini_core u0 (
      .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .dmem_req(dmem_req), .dmem_we(dmem_we), .dmem_dword(dmem_dword),
      .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
      .illegal(illegal)
   );

   assign imem_rdata = prog[imem_addr[6:2]];
   always_comb begin
      for (int i = 0; i < 8; i++) dmem_rdata[8*i +: 8] = dm[dmem_addr[7:0] + 8'(i)];
   end

   function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] b, logic [4:0] a,
                                         logic [2:0] f3, logic [4:0] d, logic [6:0] op);
      return {f7, b, a, f3, d, op};
   endfunction
   function automatic logic [31:0] enc_i(logic [11:0] im, logic [4:0] a, logic [2:0] f3,
                                         logic [4:0] d, logic [6:0] op);
      return {im, a, f3, d, op};
   endfunction
   function automatic logic [31:0] enc_s(logic [11:0] im, logic [4:0] b, logic [4:0] a,
                                         logic [2:0] f3);
      return {im[11:5], b, a, f3, im[4:0], O_ST};
   endfunction
   function automatic logic [31:0] addi(logic [4:0] d, logic [4:0] a, logic [11:0] im);
      return enc_i(im, a, 3'b000, d, O_IMM);
   endfunction
   function automatic logic [31:0] sd(logic [4:0] b, logic [4:0] a, logic [11:0] im);
      return enc_s(im, b, a, 3'b011);
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 32; i++) prog[i] = NOP;
   endtask

   task automatic restart();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      cur = 0;
   endtask

   task automatic at(int k);
      repeat (k - cur) @(negedge clk);
      cur = k;
   endtask

   // checks a store issued by the instruction at index k
   task automatic store_at(int k, string req, logic dw, logic [63:0] ad, logic [63:0] wd);
      at(k);
      chk(req, {62'd0, dmem_req, dmem_we}, 64'd3);
      chk(req, {63'd0, dmem_dword}, {63'd0, dw});
      chk(req, dmem_addr, ad);
      chk(req, dmem_wdata, wd);
   endtask

   task automatic t_reset();
      clear_prog();
      prog[0] = sd(5'd7, 5'd0, 12'd0);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 pc held in reset", imem_addr, 64'd0);
      restart();
      chk("R1 pc after reset", imem_addr, 64'd0);
      store_at(0, "R1 register reset value", 1'b1, 64'd0, 64'd0);
      at(1);
      chk("R2 pc step", imem_addr, 64'd4);
      at(5);
      chk("R2 pc after five", imem_addr, 64'd20);
   endtask

   task automatic t_add();
      clear_prog();
      prog[0] = addi(5'd20, 5'd0, 12'd100);
      prog[1] = addi(5'd21, 5'd0, 12'd23);
      prog[2] = 32'h015A04B3;
      prog[3] = sd(5'd9, 5'd0, 12'd0);
      prog[4] = addi(5'd10, 5'd0, 12'd5);
      prog[5] = addi(5'd6, 5'd0, 12'd7);
      prog[6] = 32'h00650333;
      prog[7] = sd(5'd6, 5'd0, 12'd8);
      restart();
      at(2);
      chk("R4 add not illegal", {63'd0, illegal}, 64'd0);
      chk("R4 add no mem", {63'd0, dmem_req}, 64'd0);
      store_at(3, "R4 x9=x20+x21", 1'b1, 64'd0, 64'd123);
      store_at(7, "R4 x6=x10+x6", 1'b1, 64'd8, 64'd12);
   endtask

   task automatic t_sub();
      clear_prog();
      prog[0] = addi(5'd1, 5'd0, 12'd10);
      prog[1] = addi(5'd2, 5'd0, 12'd25);
      prog[2] = enc_r(7'b0100000, 5'd2, 5'd1, 3'b000, 5'd3, O_REG);
      prog[3] = sd(5'd3, 5'd0, 12'd16);
      prog[4] = enc_r(7'b0100000, 5'd1, 5'd2, 3'b000, 5'd4, O_REG);
      prog[5] = sd(5'd4, 5'd0, 12'd16);
      restart();
      store_at(3, "R5 sub negative", 1'b1, 64'd16, 64'hFFFF_FFFF_FFFF_FFF1);
      store_at(5, "R5 sub positive", 1'b1, 64'd16, 64'd15);
   endtask

   task automatic t_addi();
      clear_prog();
      prog[0] = addi(5'd5, 5'd0, 12'hFFF);
      prog[1] = addi(5'd6, 5'd5, 12'h800);
      prog[2] = sd(5'd6, 5'd0, 12'd0);
      prog[3] = addi(5'd7, 5'd0, 12'h7FF);
      prog[4] = sd(5'd7, 5'd0, 12'd0);
      prog[5] = sd(5'd5, 5'd0, 12'd0);
      restart();
      store_at(2, "R6 addi -1 then -2048", 1'b1, 64'd0, 64'hFFFF_FFFF_FFFF_F7FF);
      store_at(4, "R6 addi +2047", 1'b1, 64'd0, 64'd2047);
      store_at(5, "R6 addi -1", 1'b1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF);
   endtask

   task automatic t_slli();
      clear_prog();
      prog[0] = addi(5'd1, 5'd0, 12'd3);
      prog[1] = enc_i({6'd0, 6'd40}, 5'd1, 3'b001, 5'd2, O_IMM);
      prog[2] = sd(5'd2, 5'd0, 12'd0);
      prog[3] = addi(5'd3, 5'd0, 12'd1);
      prog[4] = enc_i({6'd0, 6'd63}, 5'd3, 3'b001, 5'd4, O_IMM);
      prog[5] = sd(5'd4, 5'd0, 12'd0);
      prog[6] = enc_i({6'b010000, 6'd3}, 5'd3, 3'b001, 5'd4, O_IMM);
      restart();
      store_at(2, "R7 slli by 40", 1'b1, 64'd0, 64'd3 << 40);
      store_at(5, "R7 slli by 63", 1'b1, 64'd0, 64'h8000_0000_0000_0000);
      at(6);
      chk("R7 bad funct6 illegal", {63'd0, illegal}, 64'd1);
   endtask

   task automatic t_load();
      clear_prog();
      for (int i = 0; i < 256; i++) dm[i] = 8'h00;
      dm[8'h40] = 8'h01; dm[8'h41] = 8'h00; dm[8'h42] = 8'h00; dm[8'h43] = 8'h80;
      dm[8'h44] = 8'h78; dm[8'h45] = 8'h56; dm[8'h46] = 8'h34; dm[8'h47] = 8'h12;
      prog[0] = addi(5'd1, 5'd0, 12'h050);
      prog[1] = enc_i(12'hFF0, 5'd1, 3'b011, 5'd2, O_LD);
      prog[2] = sd(5'd2, 5'd0, 12'd0);
      prog[3] = enc_i(12'hFF0, 5'd1, 3'b010, 5'd3, O_LD);
      prog[4] = sd(5'd3, 5'd0, 12'd8);
      prog[5] = enc_i(12'hFF4, 5'd1, 3'b010, 5'd4, O_LD);
      prog[6] = sd(5'd4, 5'd0, 12'd8);
      restart();
      at(1);
      chk("R8 ld request", {61'd0, dmem_req, dmem_we, dmem_dword}, 64'b101);
      chk("R8 ld address", dmem_addr, 64'h40);
      store_at(2, "R8 ld data", 1'b1, 64'd0, 64'h1234_5678_8000_0001);
      at(3);
      chk("R8 lw request", {61'd0, dmem_req, dmem_we, dmem_dword}, 64'b100);
      store_at(4, "R8 lw sign extend", 1'b1, 64'd8, 64'hFFFF_FFFF_8000_0001);
      store_at(6, "R8 lw positive", 1'b1, 64'd8, 64'h0000_0000_1234_5678);
   endtask

   task automatic t_store();
      clear_prog();
      prog[0] = addi(5'd1, 5'd0, 12'h100);
      prog[1] = addi(5'd2, 5'd0, 12'h5A5);
      prog[2] = addi(5'd5, 5'd0, 12'd33);
      prog[3] = enc_s(12'hFFD, 5'd2, 5'd1, 3'b010);
      prog[4] = sd(5'd2, 5'd0, 12'd5);
      prog[5] = sd(5'd5, 5'd0, 12'd0);
      prog[6] = addi(5'd6, 5'd0, 12'hFFF);
      prog[7] = enc_s(12'd0, 5'd6, 5'd0, 3'b010);
      prog[8] = sd(5'd2, 5'd0, 12'h7E0);
      restart();
      store_at(3, "R9 sw split negative offset", 1'b0, 64'hFD, 64'h5A5);
      store_at(4, "R9 sd low offset", 1'b1, 64'd5, 64'h5A5);
      store_at(5, "R9 store wrote no register", 1'b1, 64'd0, 64'd33);
      store_at(7, "R9 sw upper zero", 1'b0, 64'd0, 64'h0000_0000_FFFF_FFFF);
      store_at(8, "R9 sd upper offset", 1'b1, 64'd2016, 64'h5A5);
   endtask

   task automatic t_zero();
      clear_prog();
      prog[0] = addi(5'd0, 5'd0, 12'd55);
      prog[1] = sd(5'd0, 5'd0, 12'd24);
      prog[2] = addi(5'd1, 5'd0, 12'd9);
      prog[3] = enc_r(7'd0, 5'd1, 5'd1, 3'b000, 5'd0, O_REG);
      prog[4] = enc_r(7'd0, 5'd1, 5'd0, 3'b000, 5'd7, O_REG);
      prog[5] = sd(5'd7, 5'd0, 12'd24);
      restart();
      store_at(1, "R3 addi to x0 dropped", 1'b1, 64'd24, 64'd0);
      store_at(5, "R3 add to x0 dropped", 1'b1, 64'd24, 64'd9);
   endtask

   task automatic t_illegal();
      clear_prog();
      prog[0] = addi(5'd4, 5'd0, 12'd9);
      prog[1] = enc_r(7'b0000001, 5'd4, 5'd4, 3'b000, 5'd4, O_REG);
      prog[2] = 32'h00000073;
      prog[3] = sd(5'd4, 5'd0, 12'd0);
      prog[4] = enc_i(12'd0, 5'd0, 3'b110, 5'd4, O_LD);
      restart();
      at(0);
      chk("R10 legal flag low", {63'd0, illegal}, 64'd0);
      at(1);
      chk("R10 bad funct7", {62'd0, illegal, dmem_req}, 64'b10);
      at(2);
      chk("R10 system opcode", {62'd0, illegal, dmem_req}, 64'b10);
      chk("R10 pc advances", imem_addr, 64'd8);
      store_at(3, "R10 no register write", 1'b1, 64'd0, 64'd9);
      at(4);
      chk("R10 bad load width", {62'd0, illegal, dmem_req}, 64'b10);
      at(5);
      chk("R10 pc after", imem_addr, 64'd20);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) dm[i] = 8'h00;
      clear_prog();
      t_reset();
      t_add();
      t_sub();
      t_addi();
      t_slli();
      t_load();
      t_store();
      t_zero();
      t_illegal();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #800000;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule